// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external asynchronous byte-wide static RAM of 128K locations. Each accepted request becomes a complete strobe sequence on the memory pins. The sequence selects the device through a pair of chip selects of opposite polarity, opens a write pulse or an output-enable read window, and then deselects the device. Every pin change is made from a register on the clock edge, so the strobes are free of glitches. Each phase lasts a parameterised number of clock cycles. The integrator sets these counts from the memory's nanosecond minimums at the chosen clock period.

The data bus is split into a driven value, a driver enable and a sampled input, so that the pad ring can build the tristate. The controller drives the bus only after the write strobe has made the memory float its outputs. It never drives while the output enable is low. A read returns its byte with a one-cycle response pulse. While an access is in progress, the ready output stays low and further requests are refused.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the device is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: The memory is selected (`mem_ce1_n`=0 together with `mem_ce2`=1) only while an access is in progress, and the two selects always switch together. A write keeps them selected for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles and a read keeps them selected for ACCESS_CYC cycles.
- R3: A write holds the device selected with `mem_we_n` high for SETUP_CYC cycles, then holds `mem_we_n` low for exactly PULSE_CYC cycles. `mem_oe_n` stays high for the whole write.
- R4: During a write, `mem_dq_oe` rises only after `mem_we_n` has been low for FLOAT_CYC cycles. It stays high through the rest of the pulse and for HOLD_CYC cycles after `mem_we_n` rises, which gives PULSE_CYC-FLOAT_CYC+HOLD_CYC driven cycles. `mem_dq_out` carries the request byte, and the byte is stored at the request address.
- R5: A read holds `mem_oe_n` low, with `mem_we_n` high, for ACCESS_CYC cycles. It samples `mem_dq_in` on the edge that ends the window. `rsp_valid` is high for exactly one cycle, the cycle after the ACCESS_CYC-th edge following acceptance, and `rsp_rdata` carries the sampled byte.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. After every access the device stays deselected for at least TURN_CYC cycles before the next access selects it.
- R7: `req_ready` is high only when idle. A request is accepted on an edge where both `req_valid` and `req_ready` are high. `req_ready` stays low for SETUP_CYC+PULSE_CYC+HOLD_CYC+TURN_CYC cycles after a write is accepted and for ACCESS_CYC+TURN_CYC cycles after a read is accepted. A request presented while `req_ready` is low has no effect.
- R8: `mem_addr` holds the accepted address, unchanged, for every cycle in which the device is selected, and it reaches all 17 bits (0 through 0x1FFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 8 | Data sampled from the memory |

## Verification
If the phase counter or the state register goes wrong, the error shows at the pins within the same access. A strobe pulse is one cycle too long or too short, the response pulse moves or is missing, or the ready output returns early or late. The bench counts these pulse widths cycle by cycle at the ports. A bad driver-enable decode appears at once as an overlap with the output enable or the write strobe. A latched address or data register that loads at the wrong time appears as a wrong byte on a later read back through a behavioural memory model.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int CW         = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int FLOAT_CYC  = 1,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RWAIT, ST_TURN
  } st_t;

  st_t           state, nxt;
  logic [CW-1:0] cnt, cnt_d, phase_len;
  logic          phase_end, accept, sel_d;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    case (state)
      ST_WSETUP: phase_len = CW'(SETUP_CYC);
      ST_WPULSE: phase_len = CW'(PULSE_CYC);
      ST_WHOLD:  phase_len = CW'(HOLD_CYC);
      ST_RWAIT:  phase_len = CW'(ACCESS_CYC);
      ST_TURN:   phase_len = CW'(TURN_CYC);
      default:   phase_len = CW'(1);
    endcase
  end

  assign phase_end = (cnt == phase_len - CW'(1));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (accept) nxt = req_write ? ST_WSETUP : ST_RWAIT;
      ST_WSETUP: if (phase_end) nxt = ST_WPULSE;
      ST_WPULSE: if (phase_end) nxt = ST_WHOLD;
      ST_WHOLD:  if (phase_end) nxt = ST_TURN;
      ST_RWAIT:  if (phase_end) nxt = ST_TURN;
      ST_TURN:   if (phase_end) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign cnt_d = (nxt != state || state == ST_IDLE) ? '0 : cnt + CW'(1);
  assign sel_d = (nxt == ST_WSETUP) || (nxt == ST_WPULSE) ||
                 (nxt == ST_WHOLD)  || (nxt == ST_RWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      state     <= nxt;
      cnt       <= cnt_d;
      mem_ce1_n <= !sel_d;
      mem_ce2   <= sel_d;
      mem_we_n  <= !(nxt == ST_WPULSE);
      mem_oe_n  <= !(nxt == ST_RWAIT);
      mem_dq_oe <= ((nxt == ST_WPULSE) && (cnt_d >= CW'(FLOAT_CYC))) ||
                   (nxt == ST_WHOLD);
      rsp_valid <= (state == ST_RWAIT) && phase_end;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (state == ST_RWAIT && phase_end) rsp_rdata <= mem_dq_in;
    end
  end

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_we_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));

  assert_drive_after_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && !$past(mem_ce1_n)) |-> $stable(mem_addr));

  assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int S = 2, P = 3, F = 1, H = 1, A = 3, T = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid;
  logic [16:0] req_addr = '0, mem_addr;
  logic [7:0]  req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.SETUP_CYC(S), .PULSE_CYC(P), .FLOAT_CYC(F), .HOLD_CYC(H),
                    .ACCESS_CYC(A), .TURN_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  // behavioural memory
  logic [7:0]  mem [int];
  logic        pend = 1'b0;
  logic [16:0] pa;
  logic [7:0]  pd;
  wire sel    = !mem_ce1_n && mem_ce2;
  wire wr_act = sel && !mem_we_n;

  always @(posedge clk) begin
    if (wr_act) begin
      pend <= 1'b1; pa <= mem_addr; pd <= mem_dq_oe ? mem_dq_out : 8'hxx;
    end else if (pend) begin
      mem[int'(pa)] = pd; pend <= 1'b0;
    end
  end

  always @* begin
    if (sel && !mem_oe_n && mem_we_n && mem.exists(int'(mem_addr)))
      mem_dq_in = mem[int'(mem_addr)];
    else
      mem_dq_in = 8'hxx;
  end

  // continuous port monitor: R2 select pairing, R6 contention and turnaround
  int  idle_run = 0, mon_err = 0;
  bit  seen_sel = 1'b0, prev_sel = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (mem_ce1_n == mem_ce2) begin
      mon_err++; $display("FAIL R2 select pair ce1_n=%b ce2=%b expected opposite", mem_ce1_n, mem_ce2);
    end
    if (mem_dq_oe && !mem_oe_n) begin
      mon_err++; $display("FAIL R6 contention dq_oe=1 oe_n=0 expected dq_oe=0");
    end
    if (sel && !prev_sel && seen_sel && idle_run < T) begin
      mon_err++; $display("FAIL R6 turnaround idle=%0d expected>=%0d", idle_run, T);
    end
    if (sel) begin seen_sel = 1'b1; idle_run = 0; end else idle_run++;
    prev_sel = sel;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  typedef struct {
    int busy, selc, welo, oelo, drv, pre_we, lat, nrsp, addr_bad, data_bad;
    logic [7:0] rdata;
  } obs_t;

  task automatic run_access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                            input bit inject, output obs_t o);
    int k;
    bit we_seen;
    o = '{default:0, rdata:8'h00};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; we_seen = 1'b0;
    while (!req_ready) begin
      o.busy++;
      if (inject && k == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00ABC; req_wdata = 8'hEE;
      end
      if (inject && k == 3) req_valid = 1'b0;
      if (sel) begin
        o.selc++;
        if (mem_addr != a) o.addr_bad++;
        if (mem_we_n && !we_seen) o.pre_we++;
      end
      if (!mem_we_n) begin o.welo++; we_seen = 1'b1; end
      if (!mem_oe_n) o.oelo++;
      if (mem_dq_oe) begin o.drv++; if (mem_dq_out != d) o.data_bad++; end
      if (rsp_valid) begin o.nrsp++; o.lat = k; o.rdata = rsp_rdata; end
      @(negedge clk); k++;
    end
    req_valid = 1'b0;
    if (rsp_valid) o.nrsp++;
  endtask

  task automatic t_reset();
    chk("R1 ce1_n", mem_ce1_n, 1); chk("R1 ce2", mem_ce2, 0);
    chk("R1 we_n", mem_we_n, 1);   chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0); chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_write_read(logic [16:0] a, logic [7:0] d);
    obs_t o;
    run_access(1'b1, a, d, 1'b0, o);
    chk("R7 write busy", o.busy, S+P+H+T);
    chk("R2 write select", o.selc, S+P+H);
    chk("R3 setup", o.pre_we, S);
    chk("R3 pulse", o.welo, P);
    chk("R3 oe during write", o.oelo, 0);
    chk("R4 driven cycles", o.drv, P-F+H);
    chk("R4 data value", o.data_bad, 0);
    chk("R8 write addr", o.addr_bad, 0);
    run_access(1'b0, a, 8'h00, 1'b0, o);
    chk("R7 read busy", o.busy, A+T);
    chk("R2 read select", o.selc, A);
    chk("R5 oe window", o.oelo, A);
    chk("R5 we during read", o.welo, 0);
    chk("R6 drive during read", o.drv, 0);
    chk("R5 latency", o.lat, A+1);
    chk("R5 pulse count", o.nrsp, 1);
    chk8("R5 read data", o.rdata, d);
    chk("R8 read addr", o.addr_bad, 0);
  endtask

  task automatic t_refused();
    obs_t o;
    mem[int'(17'h00ABC)] = 8'h5A;
    run_access(1'b1, 17'h00123, 8'h3C, 1'b1, o);
    chk("R7 busy with pending request", o.busy, S+P+H+T);
    run_access(1'b0, 17'h00ABC, 8'h00, 1'b0, o);
    chk8("R7 refused request ignored", o.rdata, 8'h5A);
    run_access(1'b0, 17'h00123, 8'h00, 1'b0, o);
    chk8("R4 in-flight write kept", o.rdata, 8'h3C);
  endtask

  task automatic t_overwrite();
    obs_t o;
    run_access(1'b1, 17'h0F0F0, 8'hFF, 1'b0, o);
    run_access(1'b1, 17'h0F0F0, 8'h00, 1'b0, o);
    run_access(1'b0, 17'h0F0F0, 8'hAA, 1'b0, o);
    chk8("R4 overwrite", o.rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read(17'h00000, 8'hA5);
    t_write_read(17'h1FFFF, 8'h5A);
    t_write_read(17'h15555, 8'h81);
    t_refused();
    t_overwrite();
    chk("R6 port monitor violations", mon_err, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule